// File: doc/BRIEF.md
# Multicycle Instruction Cycle Sequencer

This block is a control state machine that carries one instruction at a time through its sub-cycles. Every instruction starts with a fetch. An indirect sub-cycle follows only when the instruction's mode bit asks for it. Execute comes next. An interrupt sub-cycle runs only when an interrupt request meets an enabled flag. The block owns the program counter, the memory address register, the memory buffer register, the instruction register, an accumulator and a five-bit status word. It talks to one single-port memory through a request/write strobe. Each access, whether read or write, occupies the bus for a fixed `MEM_LAT` clocks, and an internal wait counter times it.

The datapath is deliberately small. It has a three-address memory add, an accumulator load, an accumulator store, a jump, an interrupt-enable instruction and a no-operation. This is enough to drive every sub-cycle path and to check clock counts exactly.

State names and transitions: `S_FETCH` (bus read at MAR = PC, to `S_INCPC` when the access ends). `S_INCPC` (PC + 1, to `S_DECODE`). `S_DECODE` (to `S_IND` when the mode bit is set, otherwise to the operand stage). `S_IND` (read the pointer, then go to the operand stage). The operand stage is `S_RDB` then `S_RDC` for an add, `S_RDA` for a load, and straight to `S_EXEC` for the rest. `S_RDB` leads to `S_RDC`, and `S_RDC` or `S_RDA` leads to `S_EXEC`. `S_EXEC` goes to `S_WR` for an add or a store. Otherwise the instruction ends there. `S_WR` ends the instruction when its write completes. When an instruction ends, the block goes to `S_INTSAVE` if an interrupt is taken, otherwise to `S_FETCH`. `S_INTSAVE` writes the PC to the save slot, then moves to `S_INTVEC`. `S_INTVEC` loads the vector and returns to `S_FETCH`.

Top module: `icycle_seq`

## Requirements
- R1: After reset the PC, accumulator, status word and interrupt enable are all zero, `instr_done` is low, and a fetch read of address 0 is on the bus at once.
- R2: The instruction word has the opcode in bits [31:28], the indirect mode bit in bit 27, and the fields A [26:18], B [17:9] and C [8:0]. A fetch reads the word at the PC into the IR and then adds one to the PC. The next fetch starts in the cycle right after `instr_done`, at the updated PC.
- R3: Every memory access holds `mem_req` high for exactly `MEM_LAT` (10) consecutive clocks, with address, write strobe and write data stable the whole time. Read data is taken in the last clock.
- R4: Clock counts, with the interrupt sub-cycle not taken: add 43, load 23, store 23, jump, no-op and enable 13. The indirect mode adds 10.
- R5: With the mode bit set, the word at address A is read first. Its low 9 bits then stand in for A as the effective address of the load, the store, the jump target or the add result.
- R6: Opcode 1 (add) writes mem[B] + mem[C] to mem[A]. It sets status bits {4 sign, 3 zero, 2 carry-out, 1 operands equal, 0 signed overflow} from that sum.
- R7: Opcode 2 loads mem[A] into the accumulator. Opcode 3 writes the accumulator to mem[A]. Neither changes the status word.
- R8: Opcode 4 loads A into the PC. Opcode 0 and every opcode above 5 change nothing but the PC increment.
- R9: When an instruction ends with interrupt enable and `irq` both high, the block writes the incremented PC to the save slot 0x1FE and loads the PC with the vector 0x0C0. It clears interrupt enable and adds 11 clocks to that instruction's count.
- R10: Opcode 5 sets interrupt enable, and it counts for the interrupt check at the end of that same instruction. While enable is low, `irq` has no effect.
- R11: `instr_done` is a one-clock pulse in the last clock of each instruction. In that clock, `instr_cycles` gives its total clock count.
- R12: The block writes to memory only in the store phases of an add, a store or an interrupt entry, and every write cycle carries `mem_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request level |
| mem_req | output | 1 | Memory access in progress |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory address (MAR) |
| mem_wdata | output | DATA_W | Write data (MBR) |
| mem_rdata | input | DATA_W | Read data from memory |
| instr_done | output | 1 | Last clock of an instruction |
| instr_cycles | output | CYC_W | Clock count of the ending instruction |
| pc_out | output | ADDR_W | Program counter |
| acc_out | output | DATA_W | Accumulator |
| status_out | output | 5 | {sign, zero, carry, equal, overflow} |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The assertions check on every cycle that a bus access holds its address, strobe and data until its final clock, and that writes always carry a request. They also check that `instr_done` is a single pulse followed at once by a fetch at the PC, and that interrupt enable drops only in the clock after an interrupt entry has moved the PC to the vector. The exact clock counts per opcode and mode, the arithmetic flag values, indirect address resolution, memory contents after stores, and the saved return address are shown only by the bench's programs.

// File: rtl/icyc_pkg.sv
`timescale 1ns/1ps
package icyc_pkg;

    localparam int FLAG_W = 5;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_LOAD  = 4'd2,
        OP_STORE = 4'd3,
        OP_JUMP  = 4'd4,
        OP_SETIE = 4'd5
    } opcode_t;

    typedef enum logic [3:0] {
        S_FETCH,
        S_INCPC,
        S_DECODE,
        S_IND,
        S_RDB,
        S_RDC,
        S_RDA,
        S_EXEC,
        S_WR,
        S_INTSAVE,
        S_INTVEC
    } state_t;

endpackage

// File: rtl/icyc_alu.sv
`timescale 1ns/1ps
module icyc_alu
    import icyc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    output logic [W-1:0]      sum,
    output logic [FLAG_W-1:0] flags
);

    logic [W:0] wide;

    always_comb begin
        wide  = {1'b0, a} + {1'b0, b};
        sum   = wide[W-1:0];
        // {sign, zero, carry, equal, overflow}
        flags = {sum[W-1],
                 (sum == '0),
                 wide[W],
                 (a == b),
                 (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1])};
    end

endmodule

// File: rtl/icyc_wait.sv
`timescale 1ns/1ps
module icyc_wait #(
    parameter int LAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic last
);

    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [CW-1:0] cnt;

    assign last = active && (cnt == CW'(LAT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (active && !last)
            cnt <= cnt + 1'b1;
        else
            cnt <= '0;
    end

endmodule

// File: rtl/icycle_seq.sv
`timescale 1ns/1ps
module icycle_seq
    import icyc_pkg::*;
#(
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 9,
    parameter int                MEM_LAT   = 10,
    parameter int                CYC_W     = 8,
    parameter logic [ADDR_W-1:0] SAVE_ADDR = 9'h1FE,
    parameter logic [ADDR_W-1:0] VEC_ADDR  = 9'h0C0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              instr_done,
    output logic [CYC_W-1:0]  instr_cycles,
    output logic [ADDR_W-1:0] pc_out,
    output logic [DATA_W-1:0] acc_out,
    output logic [FLAG_W-1:0] status_out,
    output logic              int_en
);

    // instruction layout: opcode | mode | A | B | C, no spare bits
    localparam int OP_HI   = DATA_W - 1;
    localparam int OP_LO   = DATA_W - 4;
    localparam int IND_BIT = DATA_W - 5;
    localparam int FA_LO   = 2 * ADDR_W;
    localparam int FB_LO   = ADDR_W;

    state_t state, state_nx;

    logic [ADDR_W-1:0] pc, mar, ea;
    logic [DATA_W-1:0] mbr, ir, acc, opb;
    logic [FLAG_W-1:0] flags;
    logic              ie, ie_nx;
    logic [CYC_W-1:0]  cyc;

    logic              access, acc_last, fin, take_int;
    logic [3:0]        op;
    logic              ind_mode;
    logic [ADDR_W-1:0] fa, fb, fc, pc_end;
    logic [DATA_W-1:0] alu_sum;
    logic [FLAG_W-1:0] alu_flags;

    assign op       = ir[OP_HI:OP_LO];
    assign ind_mode = ir[IND_BIT];
    assign fa       = ir[FA_LO +: ADDR_W];
    assign fb       = ir[FB_LO +: ADDR_W];
    assign fc       = ir[0 +: ADDR_W];

    function automatic state_t operand_state(input logic [3:0] o);
        if (o == OP_ADD)
            return S_RDB;
        else if (o == OP_LOAD)
            return S_RDA;
        else
            return S_EXEC;
    endfunction

    icyc_wait #(.LAT(MEM_LAT)) u_wait (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (access),
        .last   (acc_last)
    );

    icyc_alu #(.W(DATA_W)) u_alu (
        .a     (opb),
        .b     (mbr),
        .sum   (alu_sum),
        .flags (alu_flags)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_FETCH;
        else
            state <= state_nx;
    end

    // next state and end-of-instruction decision
    always_comb begin
        state_nx = state;
        fin      = 1'b0;
        unique case (state)
            S_FETCH:      if (acc_last) state_nx = S_INCPC;
            S_INCPC:      state_nx = S_DECODE;
            S_DECODE:     state_nx = ind_mode ? S_IND : operand_state(op);
            S_IND:        if (acc_last) state_nx = operand_state(op);
            S_RDB:        if (acc_last) state_nx = S_RDC;
            S_RDC, S_RDA: if (acc_last) state_nx = S_EXEC;
            S_EXEC: begin
                if (op == OP_ADD || op == OP_STORE)
                    state_nx = S_WR;
                else
                    fin = 1'b1;
            end
            S_WR:         if (acc_last) fin = 1'b1;
            S_INTSAVE:    if (acc_last) state_nx = S_INTVEC;
            S_INTVEC:     state_nx = S_FETCH;
            default:      state_nx = S_FETCH;
        endcase
        ie_nx = ie;
        if (state == S_EXEC && op == OP_SETIE)
            ie_nx = 1'b1;
        take_int = fin && ie_nx && irq;
        if (fin)
            state_nx = take_int ? S_INTSAVE : S_FETCH;
    end

    // outputs
    always_comb begin
        access = (state == S_FETCH) || (state == S_IND) || (state == S_RDB) ||
                 (state == S_RDC) || (state == S_RDA) || (state == S_WR) ||
                 (state == S_INTSAVE);
        mem_req      = access;
        mem_we       = (state == S_WR) || (state == S_INTSAVE);
        mem_addr     = mar;
        mem_wdata    = mbr;
        pc_end       = (state == S_EXEC && op == OP_JUMP) ? ea : pc;
        instr_done   = (fin && !take_int) || (state == S_INTVEC);
        instr_cycles = cyc + 1'b1;
        pc_out       = pc;
        acc_out      = acc;
        status_out   = flags;
        int_en       = ie;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            mar   <= '0;
            ea    <= '0;
            mbr   <= '0;
            ir    <= '0;
            acc   <= '0;
            opb   <= '0;
            flags <= '0;
            ie    <= 1'b0;
            cyc   <= '0;
        end else begin
            cyc <= instr_done ? '0 : cyc + 1'b1;
            unique case (state)
                S_FETCH: begin
                    if (acc_last) begin
                        mbr <= mem_rdata;
                        ir  <= mem_rdata;
                    end
                end
                S_INCPC: pc <= pc + 1'b1;
                S_DECODE: begin
                    ea <= fa;
                    if (ind_mode || op == OP_LOAD)
                        mar <= fa;
                    else if (op == OP_ADD)
                        mar <= fb;
                end
                S_IND: begin
                    if (acc_last) begin
                        mbr <= mem_rdata;
                        ea  <= mem_rdata[ADDR_W-1:0];
                        if (op == OP_ADD)
                            mar <= fb;
                        else if (op == OP_LOAD)
                            mar <= mem_rdata[ADDR_W-1:0];
                    end
                end
                S_RDB: begin
                    if (acc_last) begin
                        opb <= mem_rdata;
                        mar <= fc;
                    end
                end
                S_RDC, S_RDA: begin
                    if (acc_last)
                        mbr <= mem_rdata;
                end
                S_EXEC: begin
                    if (op == OP_ADD) begin
                        mbr   <= alu_sum;
                        flags <= alu_flags;
                        mar   <= ea;
                    end else if (op == OP_STORE) begin
                        mbr <= acc;
                        mar <= ea;
                    end else if (op == OP_LOAD) begin
                        acc <= mbr;
                    end else if (op == OP_JUMP) begin
                        pc <= ea;
                    end else if (op == OP_SETIE) begin
                        ie <= 1'b1;
                    end
                end
                S_WR, S_INTSAVE: ;
                S_INTVEC: begin
                    pc  <= VEC_ADDR;
                    mar <= VEC_ADDR;
                    ie  <= 1'b0;
                end
                default: ;
            endcase
            if (fin) begin
                if (take_int) begin
                    mar <= SAVE_ADDR;
                    mbr <= {{(DATA_W-ADDR_W){1'b0}}, pc_end};
                end else begin
                    mar <= pc_end;
                end
            end
        end
    end

endmodule

// File: rtl/icycle_seq_chk.sv
`timescale 1ns/1ps
module icycle_seq_chk #(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 9,
    parameter int                MEM_LAT  = 10,
    parameter int                CYC_W    = 8,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 9'h0C0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              instr_done,
    input logic [CYC_W-1:0]  instr_cycles,
    input logic [ADDR_W-1:0] pc_out,
    input logic              int_en,
    input logic              acc_last
);

    localparam int MIN_CYC = MEM_LAT + 3;

    // R2: fetch begins at the PC straight after an instruction ends
    a_r2_fetch_follows: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (mem_req && !mem_we && mem_addr == pc_out));

    // R3: an access keeps its address, strobe and data until its last clock
    a_r3_access_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !acc_last) |=> (mem_req && $stable(mem_addr) &&
                                    $stable(mem_we) && $stable(mem_wdata)));

    // R4: no instruction is shorter than fetch + increment + decode/execute
    a_r4_min_count: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (instr_cycles >= CYC_W'(MIN_CYC)));

    // R9: enable falls only after an interrupt entry that set the vector
    a_r9_vector_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(int_en) |-> (pc_out == VEC_ADDR && $past(instr_done)));

    // R11: completion is a single-clock pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> !instr_done);

    // R12: a write strobe is always part of a request
    a_r12_write_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

endmodule

bind icycle_seq icycle_seq_chk #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .MEM_LAT  (MEM_LAT),
    .CYC_W    (CYC_W),
    .VEC_ADDR (VEC_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .instr_done   (instr_done),
    .instr_cycles (instr_cycles),
    .pc_out       (pc_out),
    .int_en       (int_en),
    .acc_last     (acc_last)
);

// File: tb/sim_icycle_seq.sv
`timescale 1ns/1ps
module sim_icycle_seq;

    localparam int DW = 32;
    localparam int AW = 9;
    localparam int CW = 8;
    localparam int NV = 13;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          irq;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          instr_done;
    logic [CW-1:0] instr_cycles;
    logic [AW-1:0] pc_out;
    logic [DW-1:0] acc_out;
    logic [4:0]    status_out;
    logic          int_en;

    int n_chk = 0;
    int n_err = 0;
    int wr_cnt = 0;
    bit finished = 0;

    logic [DW-1:0] mem [1 << AW];

    always #10 clk = ~clk;   // 50 MHz

    icycle_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .instr_done(instr_done), .instr_cycles(instr_cycles),
        .pc_out(pc_out), .acc_out(acc_out), .status_out(status_out),
        .int_en(int_en)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // {word, cycles, pc after, status after, acc after}
    localparam logic [95:0] VECS [NV] = '{
        {4'h1, 1'b0, 9'h090, 9'h080, 9'h081, 8'd43, 16'h001, 8'h00, 32'h0000_0000},
        {4'h1, 1'b0, 9'h091, 9'h082, 9'h083, 8'd43, 16'h002, 8'h0C, 32'h0000_0000},
        {4'h1, 1'b0, 9'h092, 9'h084, 9'h083, 8'd43, 16'h003, 8'h11, 32'h0000_0000},
        {4'h1, 1'b0, 9'h093, 9'h080, 9'h080, 8'd43, 16'h004, 8'h02, 32'h0000_0000},
        {4'h2, 1'b0, 9'h090, 9'h000, 9'h000, 8'd23, 16'h005, 8'h02, 32'h0000_000C},
        {4'h3, 1'b1, 9'h086, 9'h000, 9'h000, 8'd33, 16'h006, 8'h02, 32'h0000_000C},
        {4'h2, 1'b1, 9'h085, 9'h000, 9'h000, 8'd33, 16'h007, 8'h02, 32'h8000_0000},
        {4'h1, 1'b1, 9'h087, 9'h080, 9'h081, 8'd53, 16'h008, 8'h00, 32'h8000_0000},
        {4'h0, 1'b0, 9'h000, 9'h000, 9'h000, 8'd13, 16'h009, 8'h00, 32'h8000_0000},
        {4'h4, 1'b0, 9'h020, 9'h000, 9'h000, 8'd13, 16'h020, 8'h00, 32'h8000_0000},
        {4'h4, 1'b1, 9'h088, 9'h000, 9'h000, 8'd23, 16'h030, 8'h00, 32'h8000_0000},
        {4'h3, 1'b0, 9'h096, 9'h000, 9'h000, 8'd23, 16'h031, 8'h00, 32'h8000_0000},
        {4'hF, 1'b0, 9'h000, 9'h000, 9'h000, 8'd13, 16'h032, 8'h00, 32'h8000_0000}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input string tag);
        int t = 0;
        while (!instr_done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!instr_done) begin
            n_chk++;
            n_err++;
            $display("FAIL %s: actual no instr_done expected instr_done", tag);
        end
    endtask

    task automatic run_one(input string tag, input int exp_cyc, input logic [AW-1:0] exp_pc);
        wait_done(tag);
        chk({tag, " cycles"}, 64'(instr_cycles), 64'(exp_cyc));
        @(negedge clk);
        chk({tag, " pc"}, 64'(pc_out), 64'(exp_pc));
    endtask

    task automatic clear_mem;
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a;
        int cnt;
        int wr0;
        irq   = 1'b0;
        rst_n = 1'b0;
        clear_mem();
        mem[9'h080] = 32'd5;
        mem[9'h081] = 32'd7;
        mem[9'h082] = 32'hFFFF_FFFF;
        mem[9'h083] = 32'd1;
        mem[9'h084] = 32'h7FFF_FFFF;
        mem[9'h085] = 32'h092;
        mem[9'h086] = 32'h08A;
        mem[9'h087] = 32'h095;
        mem[9'h088] = 32'h030;
        a = '0;
        for (int i = 0; i < NV; i++) begin
            mem[a] = VECS[i][95:64];
            a = VECS[i][AW+39:40];
        end
        repeat (3) @(negedge clk);
        wr0 = wr_cnt;
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 pc", 64'(pc_out), 64'h0);
        chk("R1 acc", 64'(acc_out), 64'h0);
        chk("R1 status", 64'(status_out), 64'h0);
        chk("R1 int_en", 64'(int_en), 64'h0);
        chk("R1 done low", 64'(instr_done), 64'h0);
        chk("R1 fetch req", 64'({mem_req, mem_we, mem_addr}), 64'({1'b1, 1'b0, 9'h000}));

        // R3: first fetch occupies the bus for exactly the latency
        cnt = 0;
        while (mem_req && mem_addr == '0 && cnt < 50) begin
            cnt++;
            @(negedge clk);
        end
        chk("R3 fetch length", 64'(cnt), 64'd10);

        // R2 R4 R5 R6 R7 R8: program table
        for (int i = 0; i < NV; i++) begin
            wait_done($sformatf("R4 vec%0d", i));
            chk($sformatf("R4 vec%0d cycles", i), 64'(instr_cycles), 64'(VECS[i][63:56]));
            @(negedge clk);
            chk($sformatf("R2/R8 vec%0d pc", i), 64'(pc_out), 64'(VECS[i][AW+39:40]));
            chk($sformatf("R6 vec%0d status", i), 64'(status_out), 64'(VECS[i][36:32]));
            chk($sformatf("R7 vec%0d acc", i), 64'(acc_out), 64'(VECS[i][31:0]));
        end
        chk("R6 sum plain", 64'(mem[9'h090]), 64'd12);
        chk("R6 sum carry", 64'(mem[9'h091]), 64'd0);
        chk("R6 sum ovf", 64'(mem[9'h092]), 64'h8000_0000);
        chk("R6 sum equal", 64'(mem[9'h093]), 64'd10);
        chk("R5 store indirect", 64'(mem[9'h08A]), 64'd12);
        chk("R5 add indirect", 64'(mem[9'h095]), 64'd12);
        chk("R7 store direct", 64'(mem[9'h096]), 64'h8000_0000);
        chk("R5 pointer untouched", 64'(mem[9'h086]), 64'h08A);
        chk("R12 write cycles", 64'(wr_cnt - wr0), 64'd70);

        // R9 R10: interrupt program
        rst_n = 1'b0;
        clear_mem();
        mem[9'h000] = {4'h0, 28'h0};
        mem[9'h001] = {4'h5, 28'h0};
        mem[9'h0C0] = {4'h0, 28'h0};
        mem[9'h0C1] = {4'h5, 28'h0};
        mem[9'h0C2] = {4'h3, 1'b0, 9'h0A0, 18'h0};
        mem[9'h0A0] = 32'h55;
        irq = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        run_one("R10 irq while disabled", 13, 9'h001);
        chk("R10 enable stays low", 64'(int_en), 64'h0);
        run_one("R9 enable then entry", 24, 9'h0C0);
        chk("R9 enable cleared", 64'(int_en), 64'h0);
        chk("R9 saved pc", 64'(mem[9'h1FE]), 64'h002);
        run_one("R10 handler nop", 13, 9'h0C1);
        irq = 1'b0;
        run_one("R10 enable no irq", 13, 9'h0C2);
        chk("R10 enable set", 64'(int_en), 64'h1);
        irq = 1'b1;
        run_one("R9 entry after store", 34, 9'h0C0);
        chk("R9 saved pc after store", 64'(mem[9'h1FE]), 64'h0C3);
        chk("R7 store of zero acc", 64'(mem[9'h0A0]), 64'h0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule